// File: doc/BRIEF.md
# Wavetable Tone Voice with PWM Output

This block produces one audio voice as a single pulse-width-modulated bit. An 8-bit counter runs freely and defines a 256-cycle PWM period. Each time it wraps, the block takes one sample of the selected waveform, scales it by the note amplitude, and holds the result as the duty for the next period. Pitch is set by the stride of a 16-bit phase accumulator. The top bits of the accumulator select the waveform point. A larger stride therefore walks the waveform faster and gives a higher tone, at the cost of fewer points per cycle.

A note begins with a one-cycle start pulse. The pulse captures the waveform code, the phase stride, a duration counted in PWM periods, and an amplitude. The amplitude stays constant for the whole note, so there is no attack, decay or release. When the duration runs out, the voice falls silent and the busy flag drops.

There are five waveforms. Square, sawtooth and triangle are derived from the phase bits. Sine is read from a 64-entry table that is computed at elaboration. Noise is taken from a 15-bit shift register that steps whenever the phase accumulator overflows.

Top module: `tone_pwm_voice`

## Requirements
- R1: While reset is held and in the first cycle after it, pwm_out, busy and duty are all 0.
- R2: The PWM period is 256 cycles, counted from reset. pwm_out is high in the first `duty` cycles of each period and low in the rest. duty changes only at the period wrap, so duty 255 gives 255 high cycles and duty 0 gives none.
- R3: A start pulse loads wave_sel, step_in, dur_in and amp_in, and clears the phase to 0. This holds even while a note is playing. busy is 1 in the next cycle exactly when dur_in is nonzero.
- R4: After a start with duration D > 0, busy stays high through the next D wraps and is low right after the D-th wrap. At every wrap where busy is low, duty becomes 0.
- R5: At each wrap during a note, duty = (s * (amp + 1)) >> 8, where s is the 8-bit waveform sample. Amplitude 255 passes s unchanged, and amplitude 0 gives 0.
- R6: Let u be phase[15:8]. Code 0 (square) gives 255 when u < 128 and 0 otherwise. Code 2 (triangle) gives 2u when u < 128 and 255 - 2(u - 128) otherwise. Codes 5, 6 and 7 give 0.
- R7: Code 3 (sine) reads entry k = phase[15:10] of a 64-entry table. For that entry, h = k mod 32 and v = (h * (32 - h) * 127) / 256. The entry is 128 + v for k < 32 and 128 - v otherwise.
- R8: Code 4 (noise) gives bits [14:7] of a 15-bit shift register. The register is seeded to 1 by reset and is not touched by start. It shifts left with bit14 XOR bit13 entering bit 0, and it steps once for every wrap whose phase addition carries out of 16 bits.
- R9: Code 1 (sawtooth) gives u. The first sample of a note is taken at phase 0. The phase then grows by step_in (mod 65536) at every wrap while busy.
- R10: If start coincides with a wrap, start wins. The new note's duration is not counted down at that wrap, and the duty latched at that wrap comes from the state before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a note |
| wave_sel | input | 3 | Waveform code, captured at start |
| step_in | input | 16 | Phase stride per PWM period, captured at start |
| dur_in | input | 16 | Note length in PWM periods, captured at start |
| amp_in | input | 8 | Sustain amplitude, captured at start |
| pwm_out | output | 1 | PWM audio bit |
| busy | output | 1 | High while a note is sounding |
| duty | output | 8 | Duty value used for the current PWM period |

## Verification
Two functions can fall in the same cycle: a start pulse can arrive on the very cycle the PWM counter wraps, where the countdown and the sample latch would normally act. The bench provokes this by raising start on the cycle it predicts as counter value 255, while an earlier note is still sounding at full duty. It then judges that the duty of the following period still belongs to the old note, that a one-period note stays busy for one whole further period, and that its own scaled sample appears only at the next wrap. A restart in mid-note away from the wrap is also checked, to confirm that the countdown and the phase begin again from the new values.

// File: rtl/tpv_pkg.sv
`timescale 1ns/1ps
package tpv_pkg;
  localparam int SAMP_W = 8;
  localparam int MID    = 1 << (SAMP_W - 1);
  localparam int SPAN   = MID - 1;

  localparam logic [2:0] WV_SQUARE = 3'd0;
  localparam logic [2:0] WV_SAW    = 3'd1;
  localparam logic [2:0] WV_TRI    = 3'd2;
  localparam logic [2:0] WV_SINE   = 3'd3;
  localparam logic [2:0] WV_NOISE  = 3'd4;

  typedef logic [SAMP_W-1:0] samp_t;

  // Parabolic half-wave per half of the table, centred on MID.
  function automatic samp_t sine_entry(input int k, input int depth);
    int half, h, q, qmax, v;
    half = depth / 2;
    h    = k % half;
    q    = h * (half - h);
    qmax = (half * half) / 4;
    v    = (q * SPAN) / qmax;
    if (k < half) return samp_t'(MID + v);
    else          return samp_t'(MID - v);
  endfunction

  function automatic samp_t wave_sample(input logic [2:0] sel, input samp_t u,
                                        input samp_t sine_v, input samp_t noise_v);
    samp_t r;
    case (sel)
      WV_SQUARE: r = u[SAMP_W-1] ? '0 : '1;
      WV_SAW:    r = u;
      WV_TRI:    r = u[SAMP_W-1] ? ~{u[SAMP_W-2:0], 1'b0} : {u[SAMP_W-2:0], 1'b0};
      WV_SINE:   r = sine_v;
      WV_NOISE:  r = noise_v;
      default:   r = '0;
    endcase
    return r;
  endfunction

  function automatic samp_t scale_amp(input samp_t s, input samp_t a);
    logic [2*SAMP_W:0] sx, ax, p;
    sx = (2*SAMP_W+1)'(s);
    ax = (2*SAMP_W+1)'(a) + (2*SAMP_W+1)'(1);
    p  = sx * ax;
    return p[2*SAMP_W-1:SAMP_W];
  endfunction
endpackage

// File: rtl/tpv_pwm.sv
`timescale 1ns/1ps
module tpv_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         pwm_o
);
  assign wrap_o = &cnt_o;
  assign pwm_o  = (cnt_o < duty_i);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/tpv_phase_acc.sv
`timescale 1ns/1ps
module tpv_phase_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] phase_o,
  output logic         carry_o
);
  logic [W:0] sum;
  assign sum     = {1'b0, phase_o} + {1'b0, step_i};
  assign carry_o = adv_i & sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_o <= '0;
    else if (clr_i) phase_o <= '0;
    else if (adv_i) phase_o <= sum[W-1:0];
  end
endmodule

// File: rtl/tpv_lfsr.sv
`timescale 1ns/1ps
module tpv_lfsr #(
  parameter int W = 15,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  localparam int TAP_HI = W - 1;
  localparam int TAP_LO = W - 2;

  logic fb;
  assign fb = state_o[TAP_HI] ^ state_o[TAP_LO];

  always_ff @(posedge clk) begin
    if (!rst_n)     state_o <= SEED;
    else if (adv_i) state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/tpv_sine_rom.sv
`timescale 1ns/1ps
module tpv_sine_rom #(
  parameter int AW = 6
) (
  input  logic [AW-1:0]      idx_i,
  output tpv_pkg::samp_t     data_o
);
  localparam int DEPTH = 1 << AW;

  tpv_pkg::samp_t tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign tbl[k] = tpv_pkg::sine_entry(k, DEPTH);
  end

  assign data_o = tbl[idx_i];
endmodule

// File: rtl/tone_pwm_voice.sv
`timescale 1ns/1ps
module tone_pwm_voice #(
  parameter int PHASE_W = 16,
  parameter int DUR_W   = 16,
  parameter int ROM_AW  = 6,
  parameter int LFSR_W  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         wave_sel,
  input  logic [PHASE_W-1:0] step_in,
  input  logic [DUR_W-1:0]   dur_in,
  input  logic [7:0]         amp_in,
  output logic               pwm_out,
  output logic               busy,
  output logic [7:0]         duty
);
  import tpv_pkg::*;

  localparam int CNT_W = SAMP_W;

  logic [2:0]         wave_q;
  logic [PHASE_W-1:0] step_q;
  logic [DUR_W-1:0]   remain_q;
  samp_t              amp_q;
  logic               busy_q;
  samp_t              duty_q;

  // named events shared with the checker
  logic               wrap;
  logic               count_tick;
  logic               phase_carry;
  logic               note_end;
  logic [CNT_W-1:0]   cnt;
  logic [PHASE_W-1:0] phase_q;
  logic [LFSR_W-1:0]  lfsr_q;
  samp_t              sine_v;
  samp_t              samp;

  assign count_tick = wrap & busy_q & ~start;
  assign note_end   = count_tick & (remain_q == DUR_W'(1));

  tpv_pwm #(.W(CNT_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty_i (duty_q),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .pwm_o  (pwm_out)
  );

  tpv_phase_acc #(.W(PHASE_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start),
    .adv_i   (count_tick),
    .step_i  (step_q),
    .phase_o (phase_q),
    .carry_o (phase_carry)
  );

  tpv_lfsr #(.W(LFSR_W)) u_noise (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (phase_carry),
    .state_o (lfsr_q)
  );

  tpv_sine_rom #(.AW(ROM_AW)) u_sine (
    .idx_i  (phase_q[PHASE_W-1 -: ROM_AW]),
    .data_o (sine_v)
  );

  assign samp = wave_sample(wave_q, phase_q[PHASE_W-1 -: SAMP_W], sine_v,
                            lfsr_q[LFSR_W-1 -: SAMP_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q   <= '0;
      step_q   <= '0;
      remain_q <= '0;
      amp_q    <= '0;
      busy_q   <= 1'b0;
      duty_q   <= '0;
    end else begin
      if (start) begin
        wave_q   <= wave_sel;
        step_q   <= step_in;
        remain_q <= dur_in;
        amp_q    <= amp_in;
        busy_q   <= |dur_in;
      end else if (count_tick) begin
        remain_q <= remain_q - DUR_W'(1);
        if (note_end) busy_q <= 1'b0;
      end
      if (wrap) duty_q <= busy_q ? scale_amp(samp, amp_q) : '0;
    end
  end

  assign busy = busy_q;
  assign duty = duty_q;
endmodule

// File: rtl/tone_pwm_voice_chk.sv
`timescale 1ns/1ps
module tone_pwm_voice_chk #(
  parameter int PHASE_W = 16,
  parameter int DUR_W   = 16,
  parameter int LFSR_W  = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [DUR_W-1:0]   dur_in,
  input logic               busy,
  input logic [7:0]         duty,
  input logic               pwm_out,
  input logic               wrap,
  input logic               phase_carry,
  input logic [7:0]         cnt,
  input logic [PHASE_W-1:0] phase,
  input logic [LFSR_W-1:0]  lfsr
);
  AST_DUTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty));  // R2
  AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == 8'd0));  // R2
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 8'd0) |-> !pwm_out);  // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy == ($past(dur_in) != '0)));  // R3
  AST_START_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == '0));  // R3
  AST_BUSY_FALLS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(wrap) || $past(start)));  // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !busy) |=> (duty == 8'd0));  // R4
  AST_NOISE_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_carry |=> $stable(lfsr));  // R8
  AST_PHASE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !start) |=> $stable(phase));  // R9
endmodule

bind tone_pwm_voice tone_pwm_voice_chk #(
  .PHASE_W(PHASE_W), .DUR_W(DUR_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dur_in(dur_in), .busy(busy),
  .duty(duty), .pwm_out(pwm_out), .wrap(wrap), .phase_carry(phase_carry),
  .cnt(cnt), .phase(phase_q), .lfsr(lfsr_q)
);

// File: tb/test_tone_pwm_voice.sv
`timescale 1ns/1ps
module test_tone_pwm_voice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  wave_sel = '0;
  logic [15:0] step_in = '0;
  logic [15:0] dur_in = '0;
  logic [7:0]  amp_in = '0;
  logic        pwm_out, busy;
  logic [7:0]  duty;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [7:0]  mcnt;
  logic [14:0] lf_m = 15'd1;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) mcnt <= 8'd0;
    else        mcnt <= mcnt + 8'd1;
  end

  tone_pwm_voice i_tone_pwm_voice (
    .clk(clk), .rst_n(rst_n), .start(start), .wave_sel(wave_sel),
    .step_in(step_in), .dur_in(dur_in), .amp_in(amp_in),
    .pwm_out(pwm_out), .busy(busy), .duty(duty)
  );

  typedef struct packed {
    logic [2:0]  w;
    logic [15:0] st;
    logic [7:0]  a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd16384, 8'd255, 8'd4},
    '{3'd1, 16'd4096,  8'd255, 8'd5},
    '{3'd2, 16'd8192,  8'd127, 8'd5},
    '{3'd3, 16'd1024,  8'd255, 8'd6},
    '{3'd3, 16'd20000, 8'd200, 8'd4},
    '{3'd4, 16'd40000, 8'd255, 8'd6},
    '{3'd0, 16'd100,   8'd0,   8'd3},
    '{3'd6, 16'd500,   8'd255, 8'd3},
    '{3'd1, 16'd65535, 8'd255, 8'd3}
  };

  function automatic logic [7:0] m_wave(input logic [2:0] w, input logic [15:0] ph,
                                        input logic [14:0] lf);
    int u, k, h, v;
    u = int'(ph) / 256;
    k = int'(ph) / 1024;
    h = k % 32;
    v = (h * (32 - h) * 127) / 256;
    case (w)
      3'd0:    return (u < 128) ? 8'd255 : 8'd0;
      3'd1:    return 8'(u);
      3'd2:    return (u < 128) ? 8'(2 * u) : 8'(255 - 2 * (u - 128));
      3'd3:    return (k < 32) ? 8'(128 + v) : 8'(128 - v);
      3'd4:    return lf[14:7];
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] m_scale(input logic [7:0] s, input logic [7:0] a);
    return 8'((int'(s) * (int'(a) + 1)) / 256);
  endfunction

  function automatic logic [14:0] m_lfsr_next(input logic [14:0] lf);
    return {lf[13:0], lf[14] ^ lf[13]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] w, input logic [15:0] st, input logic [15:0] d,
                      input logic [7:0] a);
    wave_sel = w; step_in = st; dur_in = d; amp_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    while (mcnt != v) @(negedge clk);
  endtask

  task automatic next_wrap();
    do @(negedge clk); while (mcnt != 8'd0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R4: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] ph;
    logic [16:0] sum;
    logic [7:0]  e;
    string       tag;
    int          hi;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pwm", pwm_out, 0);
    check("R1 busy", busy, 0);
    check("R1 duty", duty, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 duty after release", duty, 0);

    // Vector table walk
    for (int n = 0; n < NV; n++) begin
      tag = (VECS[n].a != 8'd255) ? "R5" :
            (VECS[n].w == 3'd3) ? "R7" :
            (VECS[n].w == 3'd4) ? "R8" :
            (VECS[n].w == 3'd1) ? "R9" : "R6";
      wait_cnt(8'd10);
      fire(VECS[n].w, VECS[n].st, 16'(VECS[n].d), VECS[n].a);
      check("R3 busy at start", busy, 1);
      ph = '0;
      for (int i = 1; i <= int'(VECS[n].d); i++) begin
        e   = m_scale(m_wave(VECS[n].w, ph, lf_m), VECS[n].a);
        sum = {1'b0, ph} + {1'b0, VECS[n].st};
        ph  = sum[15:0];
        if (sum[16]) lf_m = m_lfsr_next(lf_m);
        next_wrap();
        check(tag, duty, e);
        check("R4 busy", busy, (i < int'(VECS[n].d)) ? 1 : 0);
      end
      next_wrap();
      check("R4 silent after note", duty, 0);
    end

    // R2: high-cycle count per period
    wait_cnt(8'd10);
    fire(3'd0, 16'd0, 16'd1, 8'd255);
    next_wrap();
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R2 high count duty 255", hi, 255);
    wait_cnt(8'd10);
    fire(3'd0, 16'd0, 16'd1, 8'd127);
    next_wrap();
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R2 high count duty 127", hi, 127);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R2 high count idle", hi, 0);

    // R3: zero duration never goes busy
    wait_cnt(8'd10);
    fire(3'd0, 16'd0, 16'd0, 8'd255);
    check("R3 zero duration busy", busy, 0);
    next_wrap();
    check("R3 zero duration duty", duty, 0);

    // R3: restart in mid-note
    wait_cnt(8'd10);
    fire(3'd0, 16'd0, 16'd10, 8'd255);
    next_wrap();
    next_wrap();
    check("R3 first note duty", duty, 255);
    wait_cnt(8'd50);
    fire(3'd2, 16'd0, 16'd2, 8'd255);
    next_wrap();
    check("R3 restart duty", duty, 0);
    check("R3 restart busy", busy, 1);
    next_wrap();
    check("R3 restart end busy", busy, 0);
    next_wrap();

    // R10: start on the wrap cycle
    wait_cnt(8'd10);
    fire(3'd0, 16'd0, 16'd5, 8'd255);
    next_wrap();
    check("R10 old note duty", duty, 255);
    wait_cnt(8'd255);
    fire(3'd0, 16'd0, 16'd1, 8'd127);
    check("R10 duty from old state", duty, 255);
    check("R10 busy kept", busy, 1);
    next_wrap();
    check("R10 new sample", duty, 127);
    check("R10 busy after one period", busy, 0);
    next_wrap();
    check("R10 silent", duty, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule